// File: doc/BRIEF.md
# Multi-Mode Look-Up Table Slice

This block is a slice built from two 16-bit storage tables, called F and G. One set of cells takes one of three roles, picked by a 3-bit mode input:

- **Logic.** Each table is a fixed 4-input function generator. Its contents are loaded from a parameter whenever reset is asserted.
- **Memory.** The tables form a small synchronous-write RAM with asynchronous read. The shapes are two independent 16x1 memories, one 16x2, one 32x1, or one 16x1 dual-port.
- **Shift.** Each table is a 16-stage serial shift register whose output tap is picked by the address.

Each table's read result drives a direct combinational output and also the D input of an output flip-flop with a clock enable. The last stage of each table is always visible as a cascade output.

Reset is asynchronous and active low, and its release is synchronised inside the block. Asserting reset reloads both tables with their parameter values and clears the output flip-flops. A user configures the slice as a function generator by choosing the parameter values. A user configures it as scratch storage or a delay line by holding the mode input at a RAM or shift code.

Top module: `lut_slice`

## Requirements
- R1: While reset is asserted and after it is released, table F holds INIT_F and table G holds INIT_G, bit i at address i, and reg_f and reg_g are 0.
- R2: Mode 0 (logic): out_f equals F[f_in] and out_g equals G[g_in], and we changes no table bit.
- R3: Mode 1 (split RAM): on a rising clock edge with we high, F[f_in] takes d_f and G[g_in] takes d_g. out_f = F[f_in] and out_g = G[g_in] are read combinationally.
- R4: Mode 2 (16x2 RAM): f_in addresses both tables. d_f is written to F and d_g to G. out_f = F[f_in] and out_g = G[f_in], and g_in is ignored.
- R5: Mode 3 (32x1 RAM): the address is {addr_hi, f_in}. An enabled write of d_f goes to F when addr_hi is 0 and to G when addr_hi is 1. out_f reads G[f_in] when addr_hi is 1 and F[f_in] when it is 0, and out_g = G[f_in].
- R6: Mode 4 (dual-port RAM): an enabled write puts d_f into both F[f_in] and G[f_in]. out_f reads F[f_in] and out_g reads G[dp_addr].
- R7: Mode 5 (shift): on each rising edge with we high, every table moves up one bit. Bit 0 of F takes d_f and bit 0 of G takes d_g. out_f = F[f_in] and out_g = G[g_in].
- R8: casc_f and casc_g always show bit 15 of F and G.
- R9: On a rising edge with reg_ce high, reg_f and reg_g take out_f and out_g. With reg_ce low they hold their values.
- R10: Mode codes 6 and 7 read like logic mode and never modify a table.
- R11: In every RAM and shift mode, an edge with we low leaves both tables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Slice mode code (0 to 7) |
| f_in | input | 4 | Inputs / address of table F (shared address in modes 2 to 4) |
| g_in | input | 4 | Inputs / address of table G |
| addr_hi | input | 1 | Address bit 4 in 32x1 mode |
| dp_addr | input | 4 | Read address of the second port in dual-port mode |
| d_f | input | 1 | Write data or shift input for F |
| d_g | input | 1 | Write data or shift input for G |
| we | input | 1 | Write / shift enable |
| reg_ce | input | 1 | Clock enable of the output flip-flops |
| out_f | output | 1 | Combinational output of the F path |
| out_g | output | 1 | Combinational output of the G path |
| reg_f | output | 1 | Registered out_f |
| reg_g | output | 1 | Registered out_g |
| casc_f | output | 1 | Bit 15 of F |
| casc_g | output | 1 | Bit 15 of G |

## Verification
A corrupted table bit is invisible until an address selects it. It then appears on out_f or out_g in the same cycle, because reads are combinational. For that reason the bench reads back, in a later cycle, each address that a write or an ignored write could have touched. A wrong mode decode shows up as data landing in the wrong table or address. It is exposed by the first readback through the other port or the other half of the deep address. A shift fault shows on the taps and on the cascade pins one edge after the bad shift.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_LOGIC     = 3'd0,
    MODE_RAM_SPLIT = 3'd1,
    MODE_RAM_WIDE  = 3'd2,
    MODE_RAM_DEEP  = 3'd3,
    MODE_RAM_DUAL  = 3'd4,
    MODE_SHIFT     = 3'd5
  } slice_mode_e;

  localparam int NUM_TABLES = 2;
  localparam int TBL_F      = 0;
  localparam int TBL_G      = 1;

endpackage

// File: rtl/lut_slice_ctrl.sv
module lut_slice_ctrl
  import lut_slice_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [MODE_W-1:0]                mode_i,
  input  logic [AW-1:0]                    f_in_i,
  input  logic [AW-1:0]                    g_in_i,
  input  logic                             hi_i,
  input  logic [AW-1:0]                    dp_i,
  input  logic                             d_f_i,
  input  logic                             d_g_i,
  input  logic                             we_i,
  output logic [NUM_TABLES-1:0]            wr_en_o,
  output logic [NUM_TABLES-1:0][AW-1:0]    wr_idx_o,
  output logic [NUM_TABLES-1:0]            wr_bit_o,
  output logic [NUM_TABLES-1:0]            sh_en_o,
  output logic [NUM_TABLES-1:0]            sh_bit_o,
  output logic [NUM_TABLES-1:0][AW-1:0]    rd_idx_o,
  output logic                             sel_hi_o
);

  always_comb begin
    wr_en_o  = '0;
    sh_en_o  = '0;
    sel_hi_o = 1'b0;
    wr_idx_o[TBL_F] = f_in_i;
    wr_idx_o[TBL_G] = f_in_i;
    wr_bit_o[TBL_F] = d_f_i;
    wr_bit_o[TBL_G] = d_g_i;
    sh_bit_o[TBL_F] = d_f_i;
    sh_bit_o[TBL_G] = d_g_i;
    rd_idx_o[TBL_F] = f_in_i;
    rd_idx_o[TBL_G] = g_in_i;
    case (mode_i)
      MODE_RAM_SPLIT: begin
        wr_en_o         = {NUM_TABLES{we_i}};
        wr_idx_o[TBL_G] = g_in_i;
      end
      MODE_RAM_WIDE: begin
        wr_en_o         = {NUM_TABLES{we_i}};
        rd_idx_o[TBL_G] = f_in_i;
      end
      MODE_RAM_DEEP: begin
        wr_en_o[TBL_F]  = we_i & ~hi_i;
        wr_en_o[TBL_G]  = we_i & hi_i;
        wr_bit_o[TBL_G] = d_f_i;
        rd_idx_o[TBL_G] = f_in_i;
        sel_hi_o        = hi_i;
      end
      MODE_RAM_DUAL: begin
        wr_en_o         = {NUM_TABLES{we_i}};
        wr_bit_o[TBL_G] = d_f_i;
        rd_idx_o[TBL_G] = dp_i;
      end
      MODE_SHIFT: begin
        sh_en_o = {NUM_TABLES{we_i}};
      end
      default: begin
      end
    endcase
  end

  // R2 / R10: logic and unused codes issue no table update
  a_r10_logic_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOGIC || mode_i > MODE_SHIFT) |-> (wr_en_o == '0 && sh_en_o == '0));

  // R5: deep mode writes at most one table
  a_r5_deep_one_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RAM_DEEP) |-> $onehot0(wr_en_o));

  // R7 / R11: shifting and random writes never coexist
  a_r7_shift_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_en_o != '0) |-> (wr_en_o == '0));

endmodule

// File: rtl/lut_slice_table.sv
module lut_slice_table #(
  parameter int              AW    = 4,
  parameter int              DEPTH = 1 << AW,
  parameter logic [DEPTH-1:0] INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          wr_bit_i,
  input  logic          sh_en_i,
  input  logic          sh_bit_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic          rd_bit_o,
  output logic          top_bit_o
);

  logic [DEPTH-1:0] mem_q;
  logic [DEPTH-1:0] mem_d;

  always_comb begin
    mem_d = mem_q;
    if (sh_en_i) begin
      mem_d = {mem_q[DEPTH-2:0], sh_bit_i};
    end else if (wr_en_i) begin
      mem_d[wr_idx_i] = wr_bit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= INIT;
    end else begin
      mem_q <= mem_d;
    end
  end

  assign rd_bit_o  = mem_q[rd_idx_i];
  assign top_bit_o = mem_q[DEPTH-1];

  // R11: no enable, no change
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !sh_en_i) |=> (mem_q == $past(mem_q)));

  // R3: an enabled write lands at its address
  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sh_en_i) |=> (mem_q[$past(wr_idx_i)] == $past(wr_bit_i)));

  // R7: shifted bit enters at position 0, old bit 0 moves to 1
  a_r7_shift_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_en_i |=> (mem_q[0] == $past(sh_bit_i) && mem_q[1] == $past(mem_q[0])));

endmodule

// File: rtl/lut_slice_outreg.sv
module lut_slice_outreg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic sel_hi_i,
  input  logic bit_f_i,
  input  logic bit_g_i,
  output logic out_f_o,
  output logic out_g_o,
  output logic reg_f_o,
  output logic reg_g_o
);

  logic reg_f_d;
  logic reg_g_d;

  assign out_f_o = sel_hi_i ? bit_g_i : bit_f_i;
  assign out_g_o = bit_g_i;

  always_comb begin
    reg_f_d = reg_f_o;
    reg_g_d = reg_g_o;
    if (ce_i) begin
      reg_f_d = out_f_o;
      reg_g_d = out_g_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_f_o <= 1'b0;
      reg_g_o <= 1'b0;
    end else begin
      reg_f_o <= reg_f_d;
      reg_g_o <= reg_g_d;
    end
  end

  // R9: disabled flops hold
  a_r9_reg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> (reg_f_o == $past(reg_f_o) && reg_g_o == $past(reg_g_o)));

  // R9: enabled flops capture the combinational outputs
  a_r9_reg_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i |=> (reg_f_o == $past(out_f_o) && reg_g_o == $past(out_g_o)));

endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int               LUT_IN = 4,
  parameter logic [15:0]      INIT_F = 16'h6996,
  parameter logic [15:0]      INIT_G = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic [LUT_IN-1:0] f_in,
  input  logic [LUT_IN-1:0] g_in,
  input  logic              addr_hi,
  input  logic [LUT_IN-1:0] dp_addr,
  input  logic              d_f,
  input  logic              d_g,
  input  logic              we,
  input  logic              reg_ce,
  output logic              out_f,
  output logic              out_g,
  output logic              reg_f,
  output logic              reg_g,
  output logic              casc_f,
  output logic              casc_g
);

  localparam int DEPTH = 1 << LUT_IN;

  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NUM_TABLES-1:0]             wr_en;
  logic [NUM_TABLES-1:0][LUT_IN-1:0] wr_idx;
  logic [NUM_TABLES-1:0]             wr_bit;
  logic [NUM_TABLES-1:0]             sh_en;
  logic [NUM_TABLES-1:0]             sh_bit;
  logic [NUM_TABLES-1:0][LUT_IN-1:0] rd_idx;
  logic [NUM_TABLES-1:0]             rd_bit;
  logic [NUM_TABLES-1:0]             top_bit;
  logic                              sel_hi;

  lut_slice_ctrl #(.AW(LUT_IN)) u_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_sync),
    .mode_i   (mode),
    .f_in_i   (f_in),
    .g_in_i   (g_in),
    .hi_i     (addr_hi),
    .dp_i     (dp_addr),
    .d_f_i    (d_f),
    .d_g_i    (d_g),
    .we_i     (we),
    .wr_en_o  (wr_en),
    .wr_idx_o (wr_idx),
    .wr_bit_o (wr_bit),
    .sh_en_o  (sh_en),
    .sh_bit_o (sh_bit),
    .rd_idx_o (rd_idx),
    .sel_hi_o (sel_hi)
  );

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    localparam logic [DEPTH-1:0] TINIT = (t == TBL_F) ? DEPTH'(INIT_F) : DEPTH'(INIT_G);
    lut_slice_table #(.AW(LUT_IN), .DEPTH(DEPTH), .INIT(TINIT)) u_table (
      .clk_i     (clk),
      .rst_ni    (rst_sync),
      .wr_en_i   (wr_en[t]),
      .wr_idx_i  (wr_idx[t]),
      .wr_bit_i  (wr_bit[t]),
      .sh_en_i   (sh_en[t]),
      .sh_bit_i  (sh_bit[t]),
      .rd_idx_i  (rd_idx[t]),
      .rd_bit_o  (rd_bit[t]),
      .top_bit_o (top_bit[t])
    );
  end

  lut_slice_outreg u_outreg (
    .clk_i    (clk),
    .rst_ni   (rst_sync),
    .ce_i     (reg_ce),
    .sel_hi_i (sel_hi),
    .bit_f_i  (rd_bit[TBL_F]),
    .bit_g_i  (rd_bit[TBL_G]),
    .out_f_o  (out_f),
    .out_g_o  (out_g),
    .reg_f_o  (reg_f),
    .reg_g_o  (reg_g)
  );

  assign casc_f = top_bit[TBL_F];
  assign casc_g = top_bit[TBL_G];

  // R1: flops are clear while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_sync |-> (reg_f == 1'b0 && reg_g == 1'b0));

  // R8: cascade bits only move on an enabled edge
  a_r8_casc_stable: assert property (@(posedge clk) disable iff (!rst_sync)
    (!we) |=> ($stable(casc_f) && $stable(casc_g)));

endmodule

// File: tb/lut_slice_bench.sv
module lut_slice_bench;

  localparam logic [15:0] IF = 16'h6996;
  localparam logic [15:0] IG = 16'h8000;
  localparam logic [15:0] PF = 16'hC35A;
  localparam logic [15:0] PG = 16'h5E87;

  typedef struct packed {
    logic [2:0] m;
    logic [3:0] fa;
    logic [3:0] ga;
    logic       hi;
    logic [3:0] ra;
    logic       df;
    logic       dg;
    logic       we;
    logic       ef;
    logic       eg;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 4'd3,  4'd15, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2
    '{3'd0, 4'd3,  4'd15, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2
    '{3'd7, 4'd1,  4'd15, 1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R10
    '{3'd7, 4'd1,  4'd15, 1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R10
    '{3'd1, 4'd2,  4'd0,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3
    '{3'd1, 4'd2,  4'd0,  1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R3
    '{3'd1, 4'd2,  4'd0,  1'b0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R11
    '{3'd2, 4'd5,  4'd9,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R4
    '{3'd2, 4'd5,  4'd1,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4
    '{3'd3, 4'd6,  4'd0,  1'b1, 4'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    '{3'd3, 4'd6,  4'd0,  1'b0, 4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5
    '{3'd3, 4'd6,  4'd0,  1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{3'd4, 4'd10, 4'd0,  1'b0, 4'd12, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
    '{3'd4, 4'd3,  4'd0,  1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6
    '{3'd4, 4'd10, 4'd0,  1'b0, 4'd10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}  // R6
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:       return "R2";
      2, 3:       return "R10";
      4, 5:       return "R3";
      6:          return "R11";
      7, 8:       return "R4";
      9, 10, 11:  return "R5";
      default:    return "R6";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = '0;
  logic [3:0] f_in = '0;
  logic [3:0] g_in = '0;
  logic       addr_hi = 1'b0;
  logic [3:0] dp_addr = '0;
  logic       d_f = 1'b0;
  logic       d_g = 1'b0;
  logic       we = 1'b0;
  logic       reg_ce = 1'b0;
  logic       out_f, out_g, reg_f, reg_g, casc_f, casc_g;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_f;
  logic [15:0] exp_g;

  always #5 clk = ~clk;

  lut_slice #(.LUT_IN(4), .INIT_F(IF), .INIT_G(IG)) u_lut_slice (
    .clk(clk), .rst_n(rst_n), .mode(mode), .f_in(f_in), .g_in(g_in),
    .addr_hi(addr_hi), .dp_addr(dp_addr), .d_f(d_f), .d_g(d_g), .we(we),
    .reg_ce(reg_ce), .out_f(out_f), .out_g(out_g), .reg_f(reg_f),
    .reg_g(reg_g), .casc_f(casc_f), .casc_g(casc_g)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic check_init(string tag);
    @(negedge clk);
    mode = 3'd0;
    we   = 1'b0;
    for (int a = 0; a < 16; a++) begin
      f_in = 4'(a);
      g_in = 4'(a);
      #1;
      check(tag, $sformatf("F[%0d]", a), out_f, IF[a]);
      check(tag, $sformatf("G[%0d]", a), out_g, IG[a]);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1", "reg_f in reset", reg_f, 1'b0);
    check("R1", "reg_g in reset", reg_g, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_init("R1");
    check("R8", "casc_f after reset", casc_f, IF[15]);
    check("R8", "casc_g after reset", casc_g, IG[15]);

    // table of vectors: read before the edge, write at the edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VEC[i].m; f_in = VEC[i].fa; g_in = VEC[i].ga;
      addr_hi = VEC[i].hi; dp_addr = VEC[i].ra;
      d_f = VEC[i].df; d_g = VEC[i].dg; we = VEC[i].we;
      #1;
      check(vtag(i), $sformatf("out_f vec %0d", i), out_f, VEC[i].ef);
      check(vtag(i), $sformatf("out_g vec %0d", i), out_g, VEC[i].eg);
    end

    // R7: fill both tables by shifting, most significant bit first
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      mode = 3'd5; we = 1'b1; d_f = PF[i]; d_g = PG[i];
    end
    @(negedge clk);
    we = 1'b0;
    for (int a = 0; a < 16; a++) begin
      f_in = 4'(a);
      g_in = 4'(a);
      #1;
      check("R7", $sformatf("F tap %0d", a), out_f, PF[a]);
      check("R7", $sformatf("G tap %0d", a), out_g, PG[a]);
    end
    check("R8", "casc_f full", casc_f, PF[15]);
    check("R8", "casc_g full", casc_g, PG[15]);

    // R11: shift mode with we low keeps contents
    @(negedge clk);
    d_f = 1'b0; d_g = 1'b1; f_in = 4'd0; g_in = 4'd0;
    #1;
    check("R11", "F tap0 idle", out_f, PF[0]);
    check("R11", "G tap0 idle", out_g, PG[0]);

    // R7 / R8: one more shift
    @(negedge clk);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    exp_f = {PF[14:0], 1'b0};
    exp_g = {PG[14:0], 1'b1};
    for (int a = 0; a < 16; a++) begin
      f_in = 4'(a);
      g_in = 4'(a);
      #1;
      check("R7", $sformatf("F tap %0d after shift", a), out_f, exp_f[a]);
      check("R7", $sformatf("G tap %0d after shift", a), out_g, exp_g[a]);
    end
    check("R8", "casc_f shifted", casc_f, exp_f[15]);
    check("R8", "casc_g shifted", casc_g, exp_g[15]);

    // R9: output flops, reset reloads tables for logic values
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "reg_f async clear", reg_f, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_init("R1");
    @(negedge clk);
    mode = 3'd0; f_in = 4'd1; g_in = 4'd15; reg_ce = 1'b1;
    @(negedge clk);
    check("R9", "reg_f load", reg_f, IF[1]);
    check("R9", "reg_g load", reg_g, IG[15]);
    reg_ce = 1'b0; f_in = 4'd3; g_in = 4'd0;
    @(negedge clk);
    check("R9", "reg_f hold", reg_f, IF[1]);
    check("R9", "reg_g hold", reg_g, IG[15]);
    reg_ce = 1'b1;
    @(negedge clk);
    check("R9", "reg_f reload", reg_f, IF[3]);
    check("R9", "reg_g reload", reg_g, IG[0]);

    finish_run();
  end

endmodule